// File: doc/BRIEF.md
# Hysteresis Current Vector Selector with Commutation Blanking

This block picks the three-leg switch command of a three-phase inverter from four hysteresis comparator bits that locate the two-axis current error relative to a square tolerance band. It keeps a little history so it can settle choices that the comparator bits leave open. Among equivalent active vectors it chooses by the last horizontal drive direction. Between the two zero-vector leg patterns it chooses the one closer to the previous command. All decisions are taken on a sample strobe.

Each time the command changes, current sensors ring for a short while. That ringing could trigger a second, spurious change. To prevent this, every commutation puts the block in a shadow copy of its new state. The shadow copy drives the same command and ignores the comparator bits for a programmable number of sample strobes. After that the block returns to the true state and evaluates normally. The base sample period can therefore stay short. A blanking length of zero gives plain sampled behaviour.

Top module: `hyst_blank_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to `cmd` = 3'b000, leaves any shadow (blanking) state, and sets the remembered horizontal direction to "up". The first sample after reset is evaluated normally.
- R2: Each axis is decoded from a comparator pair: x = `cmp[3:2]`, y = `cmp[1:0]`. Code 2'b00 means drive that axis up. Code 2'b11 means drive it down. Codes 2'b01 and 2'b10 mean in band. Unambiguous regions map as follows: x up only gives 100, x down only gives 011, x up with y up gives 110, x down with y up gives 010, x down with y down gives 001, and x up with y down gives 101.
- R3: When only y needs drive, the remembered horizontal direction decides. For y up, "up" selects 110 and "down" selects 010. For y down, "up" selects 101 and "down" selects 001. Every evaluated sample with a nonzero x drive overwrites the remembered direction.
- R4: When both axes are in band, the block outputs 3'b111 if the current command has two or more ones, and 3'b000 otherwise.
- R5: `cmd` changes only on the clock edge at which `sample_en` is high. With `sample_en` low it holds, whatever `cmp` does.
- R6: With `blank_len` = N > 0, a command change starts a window covering the next N samples. During that window `cmd` is held, and the comparator bits and the remembered direction are ignored. Sample N+1 is evaluated.
- R7: Input changes during a window neither extend nor restart it. A new window starts only from a new command change at an evaluated sample.
- R8: With `blank_len` = 0, no window is started, and every sample is evaluated.
- R9: The window length is taken from `blank_len` at the commutating sample. Changing `blank_len` during a window does not alter that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Sample strobe, one clock wide |
| cmp | input | 4 | Comparator bits: x pair [3:2], y pair [1:0] |
| blank_len | input | CNT_W | Samples ignored after each commutation |
| cmd | output | 3 | Leg switch command, one bit per leg |

## Verification
The bench injects one-sample and multi-sample glitches right after a commutation. A design that failed to hold would emit a second change inside the window, and a design that restarted the count on each glitch would release late. It drives a recovering y-only region after a window that contained x drive. This exposes a direction memory that learns from ignored samples, which would flip 010 to 110. It also covers changes to the blanking length in mid-window, a zero length with back-to-back commutations, the zero-vector choice from both parities, and a reset taken in mid-window that must leave the first following sample free.

// File: rtl/hyst_blank_pkg.sv
package hyst_blank_pkg;

    typedef logic [2:0] leg_t;

    typedef enum logic [1:0] {
        DRV_NONE = 2'd0,
        DRV_UP   = 2'd1,
        DRV_DOWN = 2'd2
    } drive_t;

    typedef struct packed {
        drive_t dx;
        drive_t dy;
    } region_t;

    typedef struct packed {
        leg_t cmd;
        logic x_up;
    } ctrl_state_t;

    localparam int unsigned NUM_AXES = 2;
    localparam int unsigned CMP_PER_AXIS = 2;
    localparam int unsigned CMP_W = NUM_AXES * CMP_PER_AXIS;

    localparam leg_t VEC_ZERO_LO = 3'b000;
    localparam leg_t VEC_ZERO_HI = 3'b111;
    localparam leg_t VEC_000 = 3'b100;
    localparam leg_t VEC_060 = 3'b110;
    localparam leg_t VEC_120 = 3'b010;
    localparam leg_t VEC_180 = 3'b011;
    localparam leg_t VEC_240 = 3'b001;
    localparam leg_t VEC_300 = 3'b101;

    function automatic drive_t axis_drive(input logic [1:0] pair);
        drive_t d;
        case (pair)
            2'b00:   d = DRV_UP;
            2'b11:   d = DRV_DOWN;
            default: d = DRV_NONE;
        endcase
        return d;
    endfunction

    function automatic leg_t pick_zero(input leg_t prev);
        int unsigned ones;
        ones = 0;
        for (int i = 0; i < 3; i++) begin
            ones += {31'd0, prev[i]};
        end
        return (ones >= 2) ? VEC_ZERO_HI : VEC_ZERO_LO;
    endfunction

endpackage

// File: rtl/hyst_region_dec.sv
module hyst_region_dec
    import hyst_blank_pkg::*;
(
    input  logic [CMP_W-1:0] cmp,
    output region_t          region
);
    drive_t axis_d [NUM_AXES];

    generate
        for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
            localparam int unsigned LSB = (NUM_AXES - 1 - a) * CMP_PER_AXIS;
            always_comb begin
                axis_d[a] = axis_drive(cmp[LSB +: CMP_PER_AXIS]);
            end
        end
    endgenerate

    always_comb begin
        region.dx = axis_d[0];
        region.dy = axis_d[1];
    end
endmodule

// File: rtl/hyst_vec_sel.sv
module hyst_vec_sel
    import hyst_blank_pkg::*;
(
    input  region_t region,
    input  leg_t    prev_cmd,
    input  logic    x_up,
    output leg_t    next_cmd,
    output logic    next_x_up
);
    always_comb begin
        next_x_up = x_up;
        unique case (region.dx)
            DRV_UP:   next_x_up = 1'b1;
            DRV_DOWN: next_x_up = 1'b0;
            default:  next_x_up = x_up;
        endcase
    end

    always_comb begin
        next_cmd = prev_cmd;
        case ({region.dx, region.dy})
            {DRV_UP,   DRV_NONE}: next_cmd = VEC_000;
            {DRV_DOWN, DRV_NONE}: next_cmd = VEC_180;
            {DRV_UP,   DRV_UP}:   next_cmd = VEC_060;
            {DRV_DOWN, DRV_UP}:   next_cmd = VEC_120;
            {DRV_DOWN, DRV_DOWN}: next_cmd = VEC_240;
            {DRV_UP,   DRV_DOWN}: next_cmd = VEC_300;
            {DRV_NONE, DRV_UP}:   next_cmd = x_up ? VEC_060 : VEC_120;
            {DRV_NONE, DRV_DOWN}: next_cmd = x_up ? VEC_300 : VEC_240;
            default:              next_cmd = pick_zero(prev_cmd);
        endcase
    end
endmodule

// File: rtl/hyst_blank_timer.sv
module hyst_blank_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_en,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             active
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] remain;

    assign active = (remain != CNT_ZERO);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= CNT_ZERO;
        end else if (sample_en) begin
            if (active) begin
                remain <= remain - CNT_ONE;
            end else if (start) begin
                remain <= len;
            end
        end
    end
endmodule

// File: rtl/hyst_blank_ctrl.sv
module hyst_blank_ctrl
    import hyst_blank_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_en,
    input  logic [3:0]       cmp,
    input  logic [CNT_W-1:0] blank_len,
    output logic [2:0]       cmd
);
    ctrl_state_t st;
    region_t     region;
    leg_t        sel_cmd;
    logic        sel_x_up;
    logic        blank_act;
    logic        eval;
    logic        commute;

    hyst_region_dec u_dec (
        .cmp    (cmp),
        .region (region)
    );

    hyst_vec_sel u_sel (
        .region    (region),
        .prev_cmd  (st.cmd),
        .x_up      (st.x_up),
        .next_cmd  (sel_cmd),
        .next_x_up (sel_x_up)
    );

    assign eval    = sample_en && !blank_act;
    assign commute = eval && (sel_cmd != st.cmd);

    hyst_blank_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .start     (commute),
        .len       (blank_len),
        .active    (blank_act)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st.cmd  <= VEC_ZERO_LO;
            st.x_up <= 1'b1;
        end else if (eval) begin
            st.cmd  <= sel_cmd;
            st.x_up <= sel_x_up;
        end
    end

    assign cmd = st.cmd;
endmodule

module hyst_blank_ctrl_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             sample_en,
    input logic [CNT_W-1:0] blank_len,
    input logic [2:0]       cmd,
    input logic [2:0]       sel_cmd,
    input logic             blank_act
);
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (cmd == 3'b000 && !blank_act));

    p_hold_no_sample_r5: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(cmd));

    p_blank_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (blank_act && sample_en) |=> $stable(cmd));

    p_blank_arm_r7: assert property (@(posedge clk) disable iff (rst)
        (sample_en && !blank_act && sel_cmd != cmd && blank_len != '0)
        |=> (blank_act && cmd == $past(sel_cmd)));

    p_no_blank_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (sample_en && !blank_act && blank_len == '0) |=> !blank_act);
endmodule

bind hyst_blank_ctrl hyst_blank_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sample_en (sample_en),
    .blank_len (blank_len),
    .cmd       (cmd),
    .sel_cmd   (sel_cmd),
    .blank_act (blank_act)
);

// File: tb/hyst_blank_ctrl_tb.sv
`timescale 1ns/1ps
module hyst_blank_ctrl_tb_top;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sample_en = 1'b0;
    logic [3:0]       cmp = 4'b0101;
    logic [CNT_W-1:0] blank_len = '0;
    logic [2:0]       cmd;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [2:0] exp_q [$];
    string      tag_q [$];

    logic [2:0] m_cmd;
    logic       m_xup;
    int         m_cnt;

    always #2.5 clk = ~clk;

    hyst_blank_ctrl #(.CNT_W(CNT_W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .cmp       (cmp),
        .blank_len (blank_len),
        .cmd       (cmd)
    );

    function automatic logic [2:0] model_pick(input logic [3:0] c);
        int dx;
        int dy;
        int ones;
        dx = (c[3:2] == 2'b00) ? 1 : (c[3:2] == 2'b11) ? -1 : 0;
        dy = (c[1:0] == 2'b00) ? 1 : (c[1:0] == 2'b11) ? -1 : 0;
        ones = m_cmd[0] + m_cmd[1] + m_cmd[2];
        if (dx == 1 && dy == 0)   return 3'b100;
        if (dx == -1 && dy == 0)  return 3'b011;
        if (dx == 1 && dy == 1)   return 3'b110;
        if (dx == -1 && dy == 1)  return 3'b010;
        if (dx == -1 && dy == -1) return 3'b001;
        if (dx == 1 && dy == -1)  return 3'b101;
        if (dy == 1)              return m_xup ? 3'b110 : 3'b010;
        if (dy == -1)             return m_xup ? 3'b101 : 3'b001;
        return (ones >= 2) ? 3'b111 : 3'b000;
    endfunction

    task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %b exp %b", tag, got, exp);
        end
    endtask

    task automatic smp(input logic [3:0] c, input string tag);
        logic [2:0] nc;
        @(negedge clk);
        cmp = c;
        sample_en = 1'b1;
        if (m_cnt > 0) begin
            m_cnt--;
        end else begin
            nc = model_pick(c);
            if (nc != m_cmd && blank_len != 0) m_cnt = blank_len;
            if (c[3:2] == 2'b00) m_xup = 1'b1;
            if (c[3:2] == 2'b11) m_xup = 1'b0;
            m_cmd = nc;
        end
        exp_q.push_back(m_cmd);
        tag_q.push_back(tag);
        @(negedge clk);
        sample_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_cmd = 3'b000;
        m_xup = 1'b1;
        m_cnt = 0;
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            if (sample_en && !rst) begin
                #2;
                if (exp_q.size() > 0) begin
                    check(tag_q.pop_front(), cmd, exp_q.pop_front());
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired got hang exp finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        m_cmd = 3'b000; m_xup = 1'b1; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset command", cmd, 3'b000);

        blank_len = 0;
        smp(4'b0101, "R4 in band from 000");
        smp(4'b0001, "R2 x up -> 100");
        smp(4'b0101, "R4 zero after 100");
        smp(4'b0100, "R3 y up, x dir up -> 110");
        smp(4'b0101, "R4 zero after 110 -> 111");
        smp(4'b1101, "R2 x down -> 011");
        smp(4'b0100, "R3 y up, x dir down -> 010");
        smp(4'b0111, "R3 y down, x dir down -> 001");
        smp(4'b0011, "R2 x up y down -> 101");
        smp(4'b0111, "R3 y down, x dir up -> 101");
        smp(4'b1100, "R2 x down y up -> 010");
        smp(4'b1111, "R2 x down y down -> 001");
        smp(4'b0000, "R8 back-to-back x up y up -> 110");
        smp(4'b1001, "R2 spurious pair in band -> 111");

        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            cmp = (i % 2 == 0) ? 4'b0001 : 4'b1111;
            @(negedge clk);
            check("R5 hold without sample", cmd, 3'b111);
        end

        blank_len = 3;
        smp(4'b0001, "R6 commutation to 100");
        smp(4'b1101, "R6 glitch ignored 1");
        smp(4'b1101, "R6 glitch ignored 2");
        smp(4'b0101, "R6 glitch ignored 3");
        smp(4'b0101, "R6 evaluated after window -> 000");
        blank_len = 1;
        smp(4'b1101, "R9 window keeps old length 1");
        smp(4'b1101, "R9 window keeps old length 2");
        smp(4'b1101, "R7 no restart by input 3");
        smp(4'b1101, "R9 released -> 011");
        smp(4'b0101, "R6 short window hold");
        smp(4'b0101, "R6 released -> 111");

        blank_len = 2;
        smp(4'b0100, "R3 y up, x dir down -> 010");
        smp(4'b0001, "R6 x drive ignored 1");
        smp(4'b0001, "R6 x drive ignored 2");
        smp(4'b0100, "R6 history untouched -> 010");

        blank_len = 0;
        smp(4'b0101, "R8 zero -> 000");
        smp(4'b0001, "R8 immediate -> 100");
        smp(4'b1101, "R8 immediate -> 011");

        blank_len = 5;
        smp(4'b0001, "R6 commutation before reset");
        do_reset();
        @(negedge clk);
        check("R1 reset in window", cmd, 3'b000);
        smp(4'b1101, "R1 window cleared -> 011");

        @(negedge clk);
        @(negedge clk);
        check("R1 scoreboard drained", {2'b00, exp_q.size() == 0}, 3'b001);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule